// File: doc/BRIEF.md
# Multiplexed LCD Waveform Generator

This block produces the common and segment drive waveforms for a multiplexed liquid-crystal panel. It is clocked by the system clock and advanced by a one-cycle reference tick at the rate of a 32.768 kHz crystal. Each output pin is reported as a three-bit level code (ground, one third, one half, two thirds or full supply), and an analog switch network elsewhere turns each code into a voltage. One static mode and five multiplexed modes are supported. Each mode fixes the number of active commons, the bias level set, and the phase length.

Per segment pin, the user gives one pixel bit for each common and a select that either puts the pin into LCD drive or makes it a plain logic output. The block holds every pin at ground while reset is asserted and for a fixed blanking interval after reset is released. It does the same in standby, with the timing frozen. Frame polarity alternates so that no net DC builds up across the glass. A new mode is taken up only at a frame boundary.

Top module: `lcd_mux_driver`

## Requirements
- R1: `mode` codes are 0 = static (1 common), 1 = half bias / 2 commons, 2 = half bias / 3 commons, 3 = half bias / 4 commons, 4 = third bias / 3 commons and 5 = third bias / 4 commons. Codes 6 and 7 behave as static. Commons with an index at or above the active count output code 0.
- R2: A frame consists of one phase for each active common. In phase c, common c is selected. A phase lasts FRAME_TICKS ticks in static mode, FRAME_TICKS/2 ticks with 2 commons, and FRAME_TICKS/4 ticks with 3 or 4 commons, which gives 1024, 512 and 256 ticks at the defaults. Polarity is 0 in the first frame after blanking and toggles at every frame boundary.
- R3: Level codes are 0 = VSS, 1 = VDD/3, 2 = VDD/2, 3 = 2VDD/3 and 4 = VDD, and no other code ever appears. A selected common is at 4 in polarity 0 and at 0 in polarity 1. In half bias a non-selected common is at 2. In third bias a non-selected common is at 1 in polarity 0 and at 3 in polarity 1.
- R4: In the multiplexed modes, an LCD segment pin s uses pixel bit `pix[4*s+c]` of the selected common c. An on pixel drives the extreme opposite to the selected common (0 in polarity 0, 4 in polarity 1). An off pixel drives 2 in half bias. In third bias an off pixel drives 3 in polarity 0 and 1 in polarity 1.
- R5: In static mode an on segment drives the extreme opposite to common 0, and an off segment drives the same code as common 0.
- R6: When `gp_sel[s]` is 1, segment pin s drives 4 if `gp_data[s]` is 1 and 0 otherwise, whatever its pixel bits.
- R7: While `rst` is high, every output is 0. The outputs stay at 0 for the first BLANK_TICKS ticks after `rst` falls (256 at the defaults). The waveform then begins at phase 0 with polarity 0.
- R8: While `standby` is high, every common and segment output (LCD or logic) is 0 and the waveform timing does not advance. When standby ends, the waveform resumes from the point where it stopped.
- R9: In a cycle where `tick` is low, the waveform timing does not advance.
- R10: A change on `mode` takes effect only at the next frame boundary. The polarity toggle at that boundary is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Reference tick enable, one cycle per 32.768 kHz period |
| standby | input | 1 | Oscillators-stopped state: blanks all outputs and freezes timing |
| mode | input | 3 | Drive mode code (R1) |
| pix | input | 4*NSEG | Pixel bits, bit 4*s+c for segment s and common c |
| gp_sel | input | NSEG | 1 = segment pin is a logic output |
| gp_data | input | NSEG | Level for pins that are logic outputs |
| com_lvl | output | 12 | Level codes of commons 0..3, 3 bits each, common c at bits 3c+2:3c |
| seg_lvl | output | 3*NSEG | Level codes of the segment pins, pin s at bits 3s+2:3s |

## Verification
All eight mode codes are run for two full frames and more, each with its own pixel and logic-output pattern. Every cycle is compared with an arithmetic model of phase, polarity and level. This exposes errors in phase length, in the count of active commons, in the bias level set and in polarity alternation. A blanking sweep and a mode change made in the middle of a frame show that the start of the waveform and the frame-boundary rule are timed to the exact cycle. Runs that pause through standby and through a low tick show whether the timing freezes and then resumes without any phase slip.

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int NSEG        = 8,
  parameter int FRAME_TICKS = 1024,
  parameter int BLANK_TICKS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              standby,
  input  logic [2:0]        mode,
  input  logic [4*NSEG-1:0] pix,
  input  logic [NSEG-1:0]   gp_sel,
  input  logic [NSEG-1:0]   gp_data,
  output logic [11:0]       com_lvl,
  output logic [3*NSEG-1:0] seg_lvl
);
  localparam int TW = $clog2(FRAME_TICKS);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam logic [TW-1:0] LEN1 = TW'(FRAME_TICKS - 1);
  localparam logic [TW-1:0] LEN2 = TW'(FRAME_TICKS / 2 - 1);
  localparam logic [TW-1:0] LEN4 = TW'(FRAME_TICKS / 4 - 1);
  localparam logic [BW-1:0] BEND = BW'(BLANK_TICKS);
  localparam logic [2:0] V0 = 3'd0, V13 = 3'd1, V12 = 3'd2, V23 = 3'd3, V1 = 3'd4;

  logic [2:0]    cur_mode;
  logic [TW-1:0] tcnt;
  logic [1:0]    phase;
  logic          pol;
  logic [BW-1:0] bcnt;
  logic [1:0]    last_ph;
  logic          third;
  logic [TW-1:0] plen;

  wire blank = (bcnt != BEND);
  wire quiet = rst | blank | standby;

  always_comb begin
    third = 1'b0;
    case (cur_mode)
      3'd1:    begin last_ph = 2'd1; plen = LEN2; end
      3'd2:    begin last_ph = 2'd2; plen = LEN4; end
      3'd3:    begin last_ph = 2'd3; plen = LEN4; end
      3'd4:    begin last_ph = 2'd2; plen = LEN4; third = 1'b1; end
      3'd5:    begin last_ph = 2'd3; plen = LEN4; third = 1'b1; end
      default: begin last_ph = 2'd0; plen = LEN1; end
    endcase
  end

  wire stat    = (last_ph == 2'd0);
  wire ph_end  = (tcnt == plen);
  wire fr_end  = ph_end && (phase == last_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt     <= '0;
      tcnt     <= '0;
      phase    <= 2'd0;
      pol      <= 1'b0;
      cur_mode <= mode;
    end else if (blank) begin
      cur_mode <= mode;
      if (tick) bcnt <= bcnt + 1'b1;
    end else if (tick && !standby) begin
      if (!ph_end) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        if (fr_end) begin
          phase    <= 2'd0;
          pol      <= ~pol;
          cur_mode <= mode;
        end else begin
          phase <= phase + 2'd1;
        end
      end
    end
  end

  wire [2:0] sel_lv  = pol ? V0 : V1;
  wire [2:0] opp_lv  = pol ? V1 : V0;
  wire [2:0] idle_lv = third ? (pol ? V23 : V13) : V12;
  wire [2:0] off_lv  = stat ? sel_lv : (third ? (pol ? V13 : V23) : V12);

  for (genvar c = 0; c < 4; c++) begin : g_com
    wire used = (2'(c) <= last_ph);
    assign com_lvl[3*c +: 3] = (quiet || !used) ? V0 :
                               (phase == 2'(c)) ? sel_lv : idle_lv;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    wire [3:0] pbits = pix[4*s +: 4];
    wire       on    = pbits[phase];
    assign seg_lvl[3*s +: 3] = quiet     ? V0 :
                               gp_sel[s] ? (gp_data[s] ? V1 : V0) :
                               on        ? opp_lv : off_lv;
  end
endmodule

// File: rtl/lcd_mux_chk.sv
module lcd_mux_chk #(
  parameter int NSEG = 8,
  parameter int TW   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic              blank,
  input logic [NSEG-1:0]   gp_sel,
  input logic [NSEG-1:0]   gp_data,
  input logic [11:0]       com_lvl,
  input logic [3*NSEG-1:0] seg_lvl,
  input logic [2:0]        cur_mode,
  input logic [1:0]        phase,
  input logic [TW-1:0]     tcnt,
  input logic              pol
);
  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (com_lvl == '0 && seg_lvl == '0));

  assert_standby_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    standby |-> (com_lvl == '0 && seg_lvl == '0));

  assert_pol_at_frame_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol) |-> (phase == 2'd0 && tcnt == '0));

  assert_mode_at_frame_R10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cur_mode) && !$past(blank)) |-> (phase == 2'd0 && tcnt == '0 && pol != $past(pol)));

  for (genvar c = 0; c < 4; c++) begin : g_cr
    assert_com_range_R3: assert property (@(posedge clk) disable iff (rst)
      com_lvl[3*c +: 3] <= 3'd4);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_sr
    assert_seg_range_R3: assert property (@(posedge clk) disable iff (rst)
      seg_lvl[3*s +: 3] <= 3'd4);
    assert_gp_level_R6: assert property (@(posedge clk) disable iff (rst)
      (gp_sel[s] && !blank && !standby) |-> (seg_lvl[3*s +: 3] == (gp_data[s] ? 3'd4 : 3'd0)));
  end
endmodule

bind lcd_mux_driver lcd_mux_chk #(.NSEG(NSEG), .TW(TW)) chk_i (
  .clk(clk), .rst(rst), .standby(standby), .blank(blank),
  .gp_sel(gp_sel), .gp_data(gp_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
  .cur_mode(cur_mode), .phase(phase), .tcnt(tcnt), .pol(pol)
);

// File: tb/lcd_mux_driver_tb_top.sv
module lcd_mux_driver_tb_top;
  localparam int PERIOD = 10;
  localparam int NSEG   = 8;
  localparam int FRAME  = 1024;
  localparam int BLANK  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b1, standby = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [4*NSEG-1:0] pix = '0;
  logic [NSEG-1:0] gp_sel = '0, gp_data = '0;
  logic [11:0] com_lvl;
  logic [3*NSEG-1:0] seg_lvl;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  lcd_mux_driver #(.NSEG(NSEG), .FRAME_TICKS(FRAME), .BLANK_TICKS(BLANK)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .standby(standby), .mode(mode), .pix(pix),
    .gp_sel(gp_sel), .gp_data(gp_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  function automatic int dty(int m);
    case (m) 1: return 2; 2, 4: return 3; 3, 5: return 4; default: return 1; endcase
  endfunction

  function automatic int pln(int m);
    int d = dty(m);
    return (d == 1) ? FRAME : (d == 2) ? FRAME/2 : FRAME/4;
  endfunction

  task automatic expect_at(int m, int n, int pbase, string tag);
    int flen = dty(m) * pln(m);
    int ph   = (n % flen) / pln(m);
    int pl   = ((n / flen) + pbase) % 2;
    bit thd  = (m == 4 || m == 5);
    logic [11:0] ec;
    logic [3*NSEG-1:0] es;
    logic [2:0] sel, opp, idl, off;
    sel = pl ? 3'd0 : 3'd4;
    opp = pl ? 3'd4 : 3'd0;
    idl = thd ? (pl ? 3'd3 : 3'd1) : 3'd2;
    off = (dty(m) == 1) ? sel : thd ? (pl ? 3'd1 : 3'd3) : 3'd2;
    for (int c = 0; c < 4; c++)
      ec[3*c +: 3] = (c >= dty(m)) ? 3'd0 : (c == ph) ? sel : idl;
    for (int s = 0; s < NSEG; s++)
      es[3*s +: 3] = gp_sel[s] ? (gp_data[s] ? 3'd4 : 3'd0) :
                     pix[4*s + ph] ? opp : off;
    checks++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      errors++;
      $display("FAIL %s mode=%0d n=%0d com=%h/%h seg=%h/%h (actual/expected)",
               tag, m, n, com_lvl, ec, seg_lvl, es);
    end
  endtask

  task automatic expect_zero(string tag);
    checks++;
    if (com_lvl !== '0 || seg_lvl !== '0) begin
      errors++;
      $display("FAIL %s com=%h seg=%h expected all zero", tag, com_lvl, seg_lvl);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start(int m);
    rst = 1'b1; mode = 3'(m);
    repeat (3) step();
    expect_zero("R7 reset");
    rst = 1'b0;
    for (int k = 1; k < BLANK; k++) begin
      step();
      expect_zero("R7 blank");
    end
    step();
  endtask

  initial begin
    step();
    for (int m = 0; m < 8; m++) begin
      pix     = 32'hA5C3_961E ^ {8{4'(m)}} ^ (32'h1 << (m * 3));
      gp_sel  = (m % 2) ? 8'hC3 : 8'h00;
      gp_data = 8'h5A ^ 8'(m);
      start(m);
      for (int n = 0; n < 2 * dty(m) * pln(m) + 8; n++) begin
        expect_at(m, n, 0, "R1 R2 R3 R4 R5 R6");
        step();
      end
    end

    gp_sel = 8'h00; pix = 32'h3C96_5AE1;
    start(0);
    for (int n = 0; n < FRAME + 2 * 1024; n++) begin
      if (n < FRAME) expect_at(0, n, 0, "R10 old");
      else           expect_at(5, n - FRAME, 1, "R10 new");
      if (n == 300) mode = 3'd5;
      step();
    end

    gp_sel = 8'h24; gp_data = 8'hFF; pix = 32'h0F1E_2D3C;
    start(4);
    for (int n = 0; n <= 100; n++) begin
      expect_at(4, n, 0, "R8 pre");
      if (n < 100) step();
    end
    standby = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      expect_zero("R8 standby");
    end
    standby = 1'b0;
    step();
    for (int n = 101; n <= 400; n++) begin
      expect_at(4, n, 0, "R8 resume");
      if (n < 400) step();
    end
    tick = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step();
      expect_at(4, 400, 0, "R9 hold");
    end
    tick = 1'b1;
    step();
    for (int n = 401; n < 900; n++) begin
      expect_at(4, n, 0, "R9 resume");
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule